// File: doc/BRIEF.md
# Operand Hazard Interlock and Bypass Selector

This block settles read-after-write hazards for the decode stage of a five-stage in-order integer pipeline. It receives decode's two source register indices, each with a flag that says whether that operand is actually consumed, and the values the register file returned for them. It also receives the destination index, valid bit and result of the instructions now in execute, memory and writeback. For each source it returns the operand decode should use: either the register-file value or a younger result taken from a later stage.

When the execute stage holds a load whose destination a consumed source needs, no value exists yet. The block then raises a load-use stall and withholds decode's hand-off. Branches are resolved in decode, so a taken branch that is waiting on such a load also makes the block tell fetch to hold. This keeps fetch from issuing a request down a path that is not yet confirmed.

The hand-off from decode to execute follows valid/ready rules. `dec_go` is the transfer strobe and is high only when `dec_vld` is high and no stall is pending. While the stall lasts, decode keeps its instruction and the upstream stages must not overwrite it. Execute then sees a bubble, and the load moves on to memory, where its result can be forwarded. Every output is combinational in the same cycle as its inputs.

Top module: `hz_interlock`

## Requirements
- R1: A source operand depends on an older instruction only when its read flag is 1, its index is nonzero and it equals the destination of a valid instruction in execute, memory or writeback. Otherwise the operand output equals the register-file value supplied for that source.
- R2: A source with index 0 never matches any stage, even when a valid stage names destination 0. It always returns the register-file value.
- R3: A stage whose valid bit is 0 is treated as having destination 0. It never supplies a forwarded value and never causes a stall.
- R4: When several stages match, the operand comes from execute first, then memory, then writeback.
- R5: `ld_use_stall` is 1 in the same cycle that a consumed, nonzero source matches the destination of a valid execute instruction whose load flag is 1. It is 0 otherwise.
- R6: `dec_go` equals `dec_vld` AND NOT `ld_use_stall`.
- R7: `fetch_hold` is 1 exactly when `dec_br_taken` and `ld_use_stall` are both 1.
- R8: A non-load producer in execute followed directly by a consumer in decode is forwarded without a stall. The operand equals the execute result and `dec_go` stays 1.
- R9: A load followed directly by its consumer stalls for exactly one cycle. In the next cycle, with the load in memory and a bubble in execute, the stall drops and the operand equals the memory result.
- R10: With all three stages invalid, both operands equal their register-file values and `ld_use_stall`, `fetch_hold` are 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| src_a_num | input | IDX_W (5) | First source register index in decode |
| src_a_rd | input | 1 | First source is consumed |
| src_a_rf | input | DATA_W (32) | Register-file value for first source |
| src_b_num | input | IDX_W (5) | Second source register index in decode |
| src_b_rd | input | 1 | Second source is consumed |
| src_b_rf | input | DATA_W (32) | Register-file value for second source |
| ex_vld | input | 1 | Execute stage holds an instruction |
| ex_dst | input | IDX_W (5) | Execute destination index |
| ex_is_load | input | 1 | Execute instruction is a load |
| ex_res | input | DATA_W (32) | Execute result |
| mem_vld | input | 1 | Memory stage holds an instruction |
| mem_dst | input | IDX_W (5) | Memory destination index |
| mem_res | input | DATA_W (32) | Memory result |
| wb_vld | input | 1 | Writeback stage holds an instruction |
| wb_dst | input | IDX_W (5) | Writeback destination index |
| wb_res | input | DATA_W (32) | Writeback result |
| dec_vld | input | 1 | Decode holds an instruction |
| dec_br_taken | input | 1 | Decode resolved a taken branch |
| opnd_a | output | DATA_W (32) | Resolved first operand |
| opnd_b | output | DATA_W (32) | Resolved second operand |
| ld_use_stall | output | 1 | Load-use hazard present |
| dec_go | output | 1 | Decode hands its instruction to execute |
| fetch_hold | output | 1 | Fetch must not issue a request |

## Verification
The hardest situation to reach is the one-cycle load-use window followed by its release. The stimulus has to replay what the surrounding pipeline would do. It first presents a load in execute that matches a consumed source. In the next cycle it moves that load to memory and leaves a bubble in execute. The bench must then see the stall exactly once and the memory value forwarded afterwards. A second difficult case has all three stages valid and naming the same destination, which checks that the youngest producer wins. Further patterns cover register zero, unread sources and invalid stages that carry matching indices, to confirm that none of them produces a match.

// File: rtl/hz_pkg.sv
package hz_pkg;
  // Producer slots, youngest first; slot order is the forwarding priority.
  localparam int unsigned NUM_PROD = 3;
  localparam int unsigned SLOT_EX  = 0;
  localparam int unsigned SLOT_MEM = 1;
  localparam int unsigned SLOT_WB  = 2;

  typedef enum logic [1:0] {
    FWD_RF  = 2'd0,
    FWD_EX  = 2'd1,
    FWD_MEM = 2'd2,
    FWD_WB  = 2'd3
  } fwd_sel_e;
endpackage

// File: rtl/hz_dst_gate.sv
// Forces a stage's destination to zero when that stage is empty.
module hz_dst_gate #(
  parameter int unsigned IDX_W = 5
) (
  input  logic             vld,
  input  logic [IDX_W-1:0] dst,
  output logic [IDX_W-1:0] dst_eff
);
  assign dst_eff = vld ? dst : '0;
endmodule

// File: rtl/hz_src_match.sv
// Compares one decode source against every producer and picks the youngest hit.
module hz_src_match
  import hz_pkg::*;
#(
  parameter int unsigned IDX_W = 5
) (
  input  logic                src_num,
  input  logic                src_rd,
  input  logic [IDX_W-1:0]    src_idx,
  input  logic [IDX_W-1:0]    prod_dst [NUM_PROD],
  output logic [NUM_PROD-1:0] hit,
  output fwd_sel_e            sel
);
  logic live;
  assign live = src_rd && src_num;

  for (genvar g = 0; g < NUM_PROD; g++) begin : g_cmp
    assign hit[g] = live && (prod_dst[g] == src_idx);
  end

  always_comb begin
    if (hit[SLOT_EX])       sel = FWD_EX;
    else if (hit[SLOT_MEM]) sel = FWD_MEM;
    else if (hit[SLOT_WB])  sel = FWD_WB;
    else                    sel = FWD_RF;
  end
endmodule

// File: rtl/hz_operand_mux.sv
// Selects the operand value from the register file or a producer result.
module hz_operand_mux
  import hz_pkg::*;
#(
  parameter int unsigned DATA_W = 32
) (
  input  fwd_sel_e          sel,
  input  logic [DATA_W-1:0] rf_val,
  input  logic [DATA_W-1:0] prod_val [NUM_PROD],
  output logic [DATA_W-1:0] opnd
);
  always_comb begin
    unique case (sel)
      FWD_EX:  opnd = prod_val[SLOT_EX];
      FWD_MEM: opnd = prod_val[SLOT_MEM];
      FWD_WB:  opnd = prod_val[SLOT_WB];
      default: opnd = rf_val;
    endcase
  end
endmodule

// File: rtl/hz_interlock.sv
module hz_interlock
  import hz_pkg::*;
#(
  parameter int unsigned DATA_W   = 32,
  parameter int unsigned NUM_REGS = 32,
  localparam int unsigned IDX_W   = $clog2(NUM_REGS)
) (
  input  logic [IDX_W-1:0]  src_a_num,
  input  logic              src_a_rd,
  input  logic [DATA_W-1:0] src_a_rf,
  input  logic [IDX_W-1:0]  src_b_num,
  input  logic              src_b_rd,
  input  logic [DATA_W-1:0] src_b_rf,
  input  logic              ex_vld,
  input  logic [IDX_W-1:0]  ex_dst,
  input  logic              ex_is_load,
  input  logic [DATA_W-1:0] ex_res,
  input  logic              mem_vld,
  input  logic [IDX_W-1:0]  mem_dst,
  input  logic [DATA_W-1:0] mem_res,
  input  logic              wb_vld,
  input  logic [IDX_W-1:0]  wb_dst,
  input  logic [DATA_W-1:0] wb_res,
  input  logic              dec_vld,
  input  logic              dec_br_taken,
  output logic [DATA_W-1:0] opnd_a,
  output logic [DATA_W-1:0] opnd_b,
  output logic              ld_use_stall,
  output logic              dec_go,
  output logic              fetch_hold
);
  localparam int unsigned NUM_SRC = 2;

  // Producer side: gate destinations with stage valid (R3).
  logic              prod_vld [NUM_PROD];
  logic [IDX_W-1:0]  prod_raw [NUM_PROD];
  logic [IDX_W-1:0]  prod_dst [NUM_PROD];
  logic [DATA_W-1:0] prod_val [NUM_PROD];

  assign prod_vld[SLOT_EX]  = ex_vld;
  assign prod_vld[SLOT_MEM] = mem_vld;
  assign prod_vld[SLOT_WB]  = wb_vld;
  assign prod_raw[SLOT_EX]  = ex_dst;
  assign prod_raw[SLOT_MEM] = mem_dst;
  assign prod_raw[SLOT_WB]  = wb_dst;
  assign prod_val[SLOT_EX]  = ex_res;
  assign prod_val[SLOT_MEM] = mem_res;
  assign prod_val[SLOT_WB]  = wb_res;

  for (genvar p = 0; p < NUM_PROD; p++) begin : g_prod
    hz_dst_gate #(.IDX_W(IDX_W)) u_gate (
      .vld     (prod_vld[p]),
      .dst     (prod_raw[p]),
      .dst_eff (prod_dst[p])
    );
  end

  // Consumer side: one matcher and mux per source.
  logic [IDX_W-1:0]    s_idx  [NUM_SRC];
  logic                s_rd   [NUM_SRC];
  logic [DATA_W-1:0]   s_rf   [NUM_SRC];
  logic [DATA_W-1:0]   s_out  [NUM_SRC];
  logic [NUM_PROD-1:0] s_hit  [NUM_SRC];
  fwd_sel_e            s_sel  [NUM_SRC];
  logic [NUM_SRC-1:0]  s_load_hit;

  assign s_idx[0] = src_a_num;
  assign s_idx[1] = src_b_num;
  assign s_rd[0]  = src_a_rd;
  assign s_rd[1]  = src_b_rd;
  assign s_rf[0]  = src_a_rf;
  assign s_rf[1]  = src_b_rf;

  for (genvar s = 0; s < NUM_SRC; s++) begin : g_src
    hz_src_match #(.IDX_W(IDX_W)) u_match (
      .src_num  (|s_idx[s]),
      .src_rd   (s_rd[s]),
      .src_idx  (s_idx[s]),
      .prod_dst (prod_dst),
      .hit      (s_hit[s]),
      .sel      (s_sel[s])
    );
    hz_operand_mux #(.DATA_W(DATA_W)) u_mux (
      .sel      (s_sel[s]),
      .rf_val   (s_rf[s]),
      .prod_val (prod_val),
      .opnd     (s_out[s])
    );
    assign s_load_hit[s] = s_hit[s][SLOT_EX] && ex_is_load;
  end

  assign opnd_a       = s_out[0];
  assign opnd_b       = s_out[1];
  assign ld_use_stall = |s_load_hit;
  assign dec_go       = dec_vld && !ld_use_stall;
  assign fetch_hold   = dec_br_taken && ld_use_stall;

  // Embedded checks on the port-level relations.
  always_comb begin
    p_zero_src_a_r2: assert (src_a_num != '0 || opnd_a == src_a_rf);
    p_zero_src_b_r2: assert (src_b_num != '0 || opnd_b == src_b_rf);
    p_unread_a_r1:   assert (src_a_rd || opnd_a == src_a_rf);
    p_unread_b_r1:   assert (src_b_rd || opnd_b == src_b_rf);
    p_idle_r10:      assert (ex_vld || mem_vld || wb_vld ||
                             (opnd_a == src_a_rf && opnd_b == src_b_rf && !ld_use_stall));
    p_ex_wins_r4:    assert (!(src_a_rd && src_a_num != '0 && ex_vld && ex_dst == src_a_num)
                             || opnd_a == ex_res);
    p_stall_load_r5: assert (!ld_use_stall || (ex_vld && ex_is_load));
    p_no_go_r6:      assert (!ld_use_stall || !dec_go);
    p_hold_r7:       assert (!fetch_hold || (dec_br_taken && ld_use_stall));
  end
endmodule

// File: tb/test_hz_interlock.sv
module test_hz_interlock;
  typedef struct packed {
    logic [4:0]  a_num; logic a_rd; logic [31:0] a_rf;
    logic [4:0]  b_num; logic b_rd; logic [31:0] b_rf;
    logic        ex_vld; logic [4:0] ex_dst; logic ex_ld; logic [31:0] ex_res;
    logic        mem_vld; logic [4:0] mem_dst; logic [31:0] mem_res;
    logic        wb_vld; logic [4:0] wb_dst; logic [31:0] wb_res;
    logic        dvld; logic brt;
  } in_t;

  typedef struct {
    logic [31:0] a, b;
    logic        stall, go, hold;
    string       tag;
  } exp_t;

  logic clk = 1'b0;
  logic rst = 1'b1;
  always #10 clk = ~clk;

  in_t stg, drv;
  logic [31:0] opnd_a, opnd_b;
  logic ld_use_stall, dec_go, fetch_hold;
  exp_t q[$];
  int n_chk = 0, n_bad = 0;
  bit done = 0;

  hz_interlock i_hz_interlock (
    .src_a_num(drv.a_num), .src_a_rd(drv.a_rd), .src_a_rf(drv.a_rf),
    .src_b_num(drv.b_num), .src_b_rd(drv.b_rd), .src_b_rf(drv.b_rf),
    .ex_vld(drv.ex_vld), .ex_dst(drv.ex_dst), .ex_is_load(drv.ex_ld), .ex_res(drv.ex_res),
    .mem_vld(drv.mem_vld), .mem_dst(drv.mem_dst), .mem_res(drv.mem_res),
    .wb_vld(drv.wb_vld), .wb_dst(drv.wb_dst), .wb_res(drv.wb_res),
    .dec_vld(drv.dvld), .dec_br_taken(drv.brt),
    .opnd_a(opnd_a), .opnd_b(opnd_b), .ld_use_stall(ld_use_stall),
    .dec_go(dec_go), .fetch_hold(fetch_hold)
  );

  // Reference from requirements R1-style rules written independently.
  function automatic logic [31:0] ref_opnd(in_t v, logic [4:0] n, logic rd, logic [31:0] rf);
    if (rd && n != 5'd0) begin
      if (v.ex_vld  && v.ex_dst  == n) return v.ex_res;
      if (v.mem_vld && v.mem_dst == n) return v.mem_res;
      if (v.wb_vld  && v.wb_dst  == n) return v.wb_res;
    end
    return rf;
  endfunction

  task automatic apply(string tag);
    exp_t e;
    logic st;
    @(negedge clk);
    drv = stg;
    st = drv.ex_vld && drv.ex_ld &&
         ((drv.a_rd && drv.a_num != 0 && drv.ex_dst == drv.a_num) ||
          (drv.b_rd && drv.b_num != 0 && drv.ex_dst == drv.b_num));
    e.a = ref_opnd(drv, drv.a_num, drv.a_rd, drv.a_rf);
    e.b = ref_opnd(drv, drv.b_num, drv.b_rd, drv.b_rf);
    e.stall = st;
    e.go = drv.dvld && !st;
    e.hold = drv.brt && st;
    e.tag = tag;
    q.push_back(e);
  endtask

  // Monitor: compares at the rising edge, inputs change only on falling edges.
  always @(posedge clk) begin
    if (q.size() > 0) begin
      exp_t e;
      e = q.pop_front();
      n_chk++;
      if (opnd_a !== e.a || opnd_b !== e.b || ld_use_stall !== e.stall ||
          dec_go !== e.go || fetch_hold !== e.hold) begin
        n_bad++;
        $display("FAIL %s: got a=%h b=%h stall=%b go=%b hold=%b exp a=%h b=%h stall=%b go=%b hold=%b",
                 e.tag, opnd_a, opnd_b, ld_use_stall, dec_go, fetch_hold,
                 e.a, e.b, e.stall, e.go, e.hold);
      end
    end
  end

  task automatic idle();
    stg = '0;
    stg.a_num = 5'd3; stg.a_rd = 1'b1; stg.a_rf = 32'hAAAA_0003;
    stg.b_num = 5'd4; stg.b_rd = 1'b1; stg.b_rf = 32'hBBBB_0004;
    stg.ex_res = 32'hE0E0_E0E0; stg.mem_res = 32'h3E3E_3E3E; stg.wb_res = 32'h7B7B_7B7B;
    stg.dvld = 1'b1;
  endtask

  initial begin
    drv = '0;
    idle();
    repeat (3) @(posedge clk);
    rst = 1'b0;
    // R10: reset-like state, every stage empty, stage indices match sources
    stg.ex_dst = 5'd3; stg.mem_dst = 5'd4; stg.wb_dst = 5'd3;
    apply("R10 all stages invalid");
    // R2: register zero never matches
    idle(); stg.a_num = 0; stg.ex_vld = 1; stg.ex_dst = 0; stg.ex_ld = 1;
    stg.mem_vld = 1; stg.mem_dst = 0;
    apply("R2 source zero");
    // R1: unread source ignores a match
    idle(); stg.b_rd = 0; stg.ex_vld = 1; stg.ex_dst = 5'd4; stg.ex_ld = 1;
    apply("R1 unread source");
    // R3: invalid execute carries matching index, memory supplies
    idle(); stg.ex_dst = 5'd3; stg.ex_ld = 1; stg.mem_vld = 1; stg.mem_dst = 5'd3;
    apply("R3 invalid stage skipped");
    // R4: all three match
    idle(); stg.ex_vld = 1; stg.ex_dst = 5'd3; stg.mem_vld = 1; stg.mem_dst = 5'd3;
    stg.wb_vld = 1; stg.wb_dst = 5'd3;
    apply("R4 execute wins");
    idle(); stg.mem_vld = 1; stg.mem_dst = 5'd4; stg.wb_vld = 1; stg.wb_dst = 5'd4;
    apply("R4 memory over writeback");
    idle(); stg.wb_vld = 1; stg.wb_dst = 5'd4;
    apply("R1 writeback only");
    // R8: back-to-back dependent ALU ops
    idle(); stg.ex_vld = 1; stg.ex_dst = 5'd3; stg.ex_res = 32'h0000_1111;
    apply("R8 alu chain cycle 1");
    idle(); stg.a_num = 5'd9; stg.ex_vld = 1; stg.ex_dst = 5'd9; stg.ex_res = 32'h0000_2222;
    stg.mem_vld = 1; stg.mem_dst = 5'd3; stg.mem_res = 32'h0000_1111;
    apply("R8 alu chain cycle 2");
    // R9: load then consumer on source b, one stall then release
    idle(); stg.ex_vld = 1; stg.ex_dst = 5'd4; stg.ex_ld = 1;
    apply("R9 load-use stall cycle");
    idle(); stg.mem_vld = 1; stg.mem_dst = 5'd4; stg.mem_res = 32'h1234_5678;
    apply("R9 release after one cycle");
    // R5: load in execute not needed
    idle(); stg.ex_vld = 1; stg.ex_dst = 5'd7; stg.ex_ld = 1;
    apply("R5 load without dependence");
    // R7: taken branch with and without stall
    idle(); stg.brt = 1; stg.ex_vld = 1; stg.ex_dst = 5'd3; stg.ex_ld = 1;
    apply("R7 branch waits on load");
    idle(); stg.brt = 1; stg.ex_vld = 1; stg.ex_dst = 5'd3;
    apply("R7 branch no stall");
    // R6: empty decode never hands off
    idle(); stg.dvld = 0;
    apply("R6 decode empty");
    idle(); stg.dvld = 0; stg.ex_vld = 1; stg.ex_dst = 5'd4; stg.ex_ld = 1;
    apply("R6 decode empty with stall");
    repeat (3) @(posedge clk);
    done = 1;
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    repeat (5000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog: got timeout exp completion");
      $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
      $finish;
    end
  end
endmodule